// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This block forms the 24-bit data address of one operand access. It covers seven addressing modes. Two of them are direct: a relocatable direct-page window and a window relative to the stack pointer. Two take a 24-bit long constant, with or without the X index added. Three go through a pointer held in bank 0: a 16-bit pointer found relative to the stack, and a 3-byte pointer found in the direct page, with or without the Y index added.

A request is a single-cycle `start` pulse. The pulse carries the mode code, up to three operand bytes, and the current D, S, X, Y, data-bank and index-width values. The block latches all of these, so none of them has to be held after the pulse. For a pointer mode the block reads the pointer bytes one at a time through a read port with one cycle of latency. It then presents the address with a one-cycle `addrValid` strobe. Alongside the address it raises `dpPenalty` when the access went through a direct page that is not at zero, which costs one extra cycle.

A `start` that arrives while a request is still in progress is ignored. Fetching instructions and performing the data access itself are the job of the surrounding core.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset `addrValid`, `dpPenalty` and `rdReq` are 0 and `effAddr` is 0.
- R2: Mode 0 (direct page) gives bank 0x00 and an offset of D + opLo, taken modulo 2^16.
- R3: Mode 1 (stack relative) gives bank 0x00 and an offset of S + opLo, taken modulo 2^16.
- R4: Mode 3 (long) gives the address {opBank, opHi, opLo}.
- R5: Mode 4 (long indexed) gives {opBank, opHi, opLo} + X, taken modulo 2^24, so a carry propagates into the bank byte.
- R6: When `idx8` = 1, only bits 7:0 of X or Y are added. The upper index bits have no effect on the address.
- R7: Mode 2 (stack relative indirect indexed) reads a 16-bit pointer from bank 0 at S+opLo, low byte first. The result is {DBR, pointer} + Y, taken modulo 2^24.
- R8: Mode 5 (direct indirect long) reads a 3-byte pointer from bank 0 at D+opLo, D+opLo+1 and D+opLo+2, in the order low, middle, bank. The result is that pointer. Mode 6 adds Y to it, modulo 2^24.
- R9: A pointer byte is requested by holding `rdReq` high with `rdAddr` for one cycle, and `rdData` is taken in the following cycle. Successive requests step the 16-bit offset by +1, with wraparound, and every request address lies in bank 0.
- R10: `dpPenalty` is 1 together with `addrValid` for modes 0, 5 and 6 when D is not 0. It is 0 for D = 0, for every other mode, and whenever `addrValid` is low.
- R11: `addrValid` is high for exactly one cycle. Counting the `start` cycle as cycle 0, it is high in cycle 2 for modes 0, 1, 3 and 4, in cycle 5 for mode 2, and in cycle 6 for modes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 3 | Addressing mode code |
| opLo | input | 8 | First operand byte (offset or address low) |
| opHi | input | 8 | Second operand byte (address high) |
| opBank | input | 8 | Third operand byte (bank) |
| regD | input | 16 | Direct-page base |
| regS | input | 16 | Stack pointer |
| regX | input | 16 | X index |
| regY | input | 16 | Y index |
| regDbr | input | 8 | Data bank |
| idx8 | input | 1 | 1 = 8-bit index width |
| rdData | input | 8 | Pointer byte returned one cycle after the request |
| rdReq | output | 1 | Pointer byte read request |
| rdAddr | output | 24 | Pointer byte address |
| effAddr | output | 24 | Effective address |
| addrValid | output | 1 | One-cycle strobe that marks `effAddr` as valid |
| dpPenalty | output | 1 | Extra-cycle flag for a relocated direct page |

## Verification
Every mode is driven with operand and register values that make the parts of the address tell each other apart. Direct-page bases near 0xFFFF show whether the bank-0 offset wraps instead of carrying into the bank. Long and pointer cases with large X or Y values show whether the carry does reach the bank byte. Index values with non-zero upper bytes under `idx8` = 1 show whether the upper bits are masked off. Because the memory model returns a different byte at every address, any swap or misordering of pointer bytes changes the address, and the log of requested read addresses confirms the base and the step order. Running the direct-page modes with D both zero and non-zero, and the stack modes with D non-zero, separates a correct penalty flag from one keyed to the wrong condition.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 24;
  localparam int BANK_W = ADDR_W - WORD_W;
  localparam int MAX_PTR = 3;
  localparam int CNT_W = $clog2(MAX_PTR + 1);

  typedef enum logic [2:0] {
    MODE_DP    = 3'd0,
    MODE_SR    = 3'd1,
    MODE_SRIY  = 3'd2,
    MODE_LONG  = 3'd3,
    MODE_LONGX = 3'd4,
    MODE_DPIL  = 3'd5,
    MODE_DPILY = 3'd6
  } eagMode_e;

  typedef struct packed {
    logic             latch;
    logic             issue;
    logic             capture;
    logic [CNT_W-1:0] fetchIdx;
    logic [CNT_W-1:0] capIdx;
    logic             finish;
  } eagStrobe_t;

  function automatic logic [CNT_W-1:0] ptrBytes(input eagMode_e m);
    case (m)
      MODE_SRIY:             return CNT_W'(2);
      MODE_DPIL, MODE_DPILY: return CNT_W'(MAX_PTR);
      default:               return '0;
    endcase
  endfunction

  function automatic logic usesDirect(input eagMode_e m);
    return (m == MODE_DP) || (m == MODE_DPIL) || (m == MODE_DPILY);
  endfunction
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] mode,
  output eagStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CALC} state_e;

  state_e           state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] need;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.latch = 1'b1;
          stateNxt = (ptrBytes(eagMode_e'(mode)) != '0) ? S_FETCH : S_CALC;
        end
      end
      S_FETCH: begin
        strobe.issue    = (cnt != need);
        strobe.capture  = (cnt != '0);
        strobe.fetchIdx = cnt;
        strobe.capIdx   = cnt - CNT_W'(1);
        if (cnt == need) stateNxt = S_CALC;
      end
      S_CALC: begin
        strobe.finish = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      need  <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && start) begin
        need <= ptrBytes(eagMode_e'(mode));
        cnt  <= '0;
      end else if (state == S_FETCH) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R9
  fetch_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_FETCH |-> cnt <= need);

  // R11
  finish_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !strobe.finish);
endmodule

// File: rtl/eag_dp.sv
module eag_dp
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eagStrobe_t        strobe,
  input  logic [2:0]        mode,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] opBank,
  input  logic [WORD_W-1:0] regD,
  input  logic [WORD_W-1:0] regS,
  input  logic [WORD_W-1:0] regX,
  input  logic [WORD_W-1:0] regY,
  input  logic [BANK_W-1:0] regDbr,
  input  logic              idx8,
  input  logic [BYTE_W-1:0] rdData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid,
  output logic              dpPenalty
);
  eagMode_e          modeL;
  logic [BYTE_W-1:0] offL, hiL, bankL;
  logic [WORD_W-1:0] dL, sL, xL, yL;
  logic [BANK_W-1:0] dbrL;
  logic [BYTE_W-1:0] ptrB [MAX_PTR];
  logic [WORD_W-1:0] idxMask, base;
  logic [ADDR_W-1:0] longAddr, ptrLong, ptrBanked, xExt, yExt, calc;

  assign idxMask = idx8 ? WORD_W'({BYTE_W{1'b1}}) : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeL <= MODE_DP;
      offL  <= '0;
      hiL   <= '0;
      bankL <= '0;
      dL    <= '0;
      sL    <= '0;
      xL    <= '0;
      yL    <= '0;
      dbrL  <= '0;
    end else if (strobe.latch) begin
      modeL <= eagMode_e'(mode);
      offL  <= opLo;
      hiL   <= opHi;
      bankL <= opBank;
      dL    <= regD;
      sL    <= regS;
      xL    <= regX & idxMask;
      yL    <= regY & idxMask;
      dbrL  <= regDbr;
    end
  end

  for (genvar k = 0; k < MAX_PTR; k++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptrB[k] <= '0;
      else if (strobe.capture && strobe.capIdx == CNT_W'(k)) ptrB[k] <= rdData;
    end
  end

  assign base   = ((modeL == MODE_SRIY) ? sL : dL) + WORD_W'(offL);
  assign rdReq  = strobe.issue;
  assign rdAddr = {BANK_W'(0), base + WORD_W'(strobe.fetchIdx)};

  assign longAddr  = {bankL, hiL, offL};
  assign ptrLong   = {ptrB[2], ptrB[1], ptrB[0]};
  assign ptrBanked = {dbrL, ptrB[1], ptrB[0]};
  assign xExt      = ADDR_W'(xL);
  assign yExt      = ADDR_W'(yL);

  always_comb begin
    case (modeL)
      MODE_DP:    calc = {BANK_W'(0), dL + WORD_W'(offL)};
      MODE_SR:    calc = {BANK_W'(0), sL + WORD_W'(offL)};
      MODE_SRIY:  calc = ptrBanked + yExt;
      MODE_LONG:  calc = longAddr;
      MODE_LONGX: calc = longAddr + xExt;
      MODE_DPIL:  calc = ptrLong;
      MODE_DPILY: calc = ptrLong + yExt;
      default:    calc = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddr   <= '0;
      addrValid <= 1'b0;
      dpPenalty <= 1'b0;
    end else begin
      addrValid <= strobe.finish;
      dpPenalty <= strobe.finish && usesDirect(modeL) && (dL != '0);
      if (strobe.finish) effAddr <= calc;
    end
  end

  // R9
  rd_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdAddr[ADDR_W-1:WORD_W] == '0);

  // R9
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && $past(rdReq) |-> rdAddr[WORD_W-1:0] == $past(rdAddr[WORD_W-1:0]) + WORD_W'(1));

  // R10
  penalty_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpPenalty |-> addrValid);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  // R3
  stack_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && modeL == MODE_SR |-> effAddr[ADDR_W-1:WORD_W] == '0);

  // R9
  no_read_at_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !addrValid);
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] opBank,
  input  logic [WORD_W-1:0] regD,
  input  logic [WORD_W-1:0] regS,
  input  logic [WORD_W-1:0] regX,
  input  logic [WORD_W-1:0] regY,
  input  logic [BANK_W-1:0] regDbr,
  input  logic              idx8,
  input  logic [BYTE_W-1:0] rdData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid,
  output logic              dpPenalty
);
  eagStrobe_t strobe;

  eag_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .mode   (mode),
    .strobe (strobe)
  );

  eag_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode      (mode),
    .opLo      (opLo),
    .opHi      (opHi),
    .opBank    (opBank),
    .regD      (regD),
    .regS      (regS),
    .regX      (regX),
    .regY      (regY),
    .regDbr    (regDbr),
    .idx8      (idx8),
    .rdData    (rdData),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .effAddr   (effAddr),
    .addrValid (addrValid),
    .dpPenalty (dpPenalty)
  );
endmodule

// File: tb/eff_addr_gen_bench.sv
module eff_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  opLo = '0, opHi = '0, opBank = '0;
  logic [15:0] regD = '0, regS = '0, regX = '0, regY = '0;
  logic [7:0]  regDbr = '0;
  logic        idx8 = 1'b0;
  logic [7:0]  rdData;
  logic        rdReq;
  logic [23:0] rdAddr, effAddr;
  logic        addrValid, dpPenalty;

  int checks = 0;
  int failures = 0;
  logic [23:0] rdLog [8];
  int rdCnt = 0;

  always #4 clk = ~clk;

  eff_addr_gen u_eff_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .opLo(opLo), .opHi(opHi), .opBank(opBank),
    .regD(regD), .regS(regS), .regX(regX), .regY(regY), .regDbr(regDbr),
    .idx8(idx8), .rdData(rdData), .rdReq(rdReq), .rdAddr(rdAddr),
    .effAddr(effAddr), .addrValid(addrValid), .dpPenalty(dpPenalty)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    rdData <= rdReq ? memByte(rdAddr) : 8'h00;
    if (rdReq && rdCnt < 8) begin
      rdLog[rdCnt] <= rdAddr;
      rdCnt <= rdCnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runCase(input string tag, input logic [2:0] m,
                         input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] bk,
                         input logic [15:0] d, input logic [15:0] s,
                         input logic [15:0] x, input logic [15:0] y,
                         input logic [7:0] dbr, input logic i8,
                         input logic [23:0] expA, input logic expP, input int expLat,
                         input int nRd, input logic [15:0] rdBase);
    int waits;
    @(negedge clk);
    rdCnt = 0;
    mode = m; opLo = lo; opHi = hi; opBank = bk;
    regD = d; regS = s; regX = x; regY = y; regDbr = dbr; idx8 = i8;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 3'd7; opLo = 8'hEE; opHi = 8'hEE; opBank = 8'hEE;
    regD = 16'hDEAD; regS = 16'hBEEF; regX = 16'hFFFF; regY = 16'hFFFF; regDbr = 8'hEE;
    waits = 0;
    while (!addrValid && waits < 20) begin
      @(negedge clk);
      waits++;
    end
    check({tag, " address"}, 32'(effAddr), 32'(expA));
    check({tag, " penalty R10"}, 32'(dpPenalty), 32'(expP));
    check({tag, " latency R11"}, 32'(waits + 1), 32'(expLat));
    check({tag, " read count R9"}, 32'(rdCnt), 32'(nRd));
    for (int k = 0; k < nRd && k < 8; k++)
      check({tag, " read address R9"}, 32'(rdLog[k]), 32'({8'h00, rdBase + 16'(k)}));
    @(negedge clk);
    check({tag, " pulse width R11"}, 32'(addrValid), 32'd0);
    check({tag, " penalty low R10"}, 32'(dpPenalty), 32'd0);
  endtask

  function automatic logic [15:0] ptr16(input logic [15:0] b);
    return {memByte({8'h00, b + 16'd1}), memByte({8'h00, b})};
  endfunction

  function automatic logic [23:0] ptr24(input logic [15:0] b);
    return {memByte({8'h00, b + 16'd2}), memByte({8'h00, b + 16'd1}), memByte({8'h00, b})};
  endfunction

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addrValid", 32'(addrValid), 32'd0);
    check("R1 dpPenalty", 32'(dpPenalty), 32'd0);
    check("R1 rdReq", 32'(rdReq), 32'd0);
    check("R1 effAddr", 32'(effAddr), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCase("R2 dp", 3'd0, 8'hF0, 8'h11, 8'h22, 16'h1234, 16'h0, 16'h0, 16'h0, 8'h33, 1'b0,
            24'h001324, 1'b1, 2, 0, 16'h0);
    runCase("R2 dp wrap", 3'd0, 8'h20, 8'h00, 8'h00, 16'hFFF0, 16'h0, 16'h0, 16'h0, 8'h7F, 1'b0,
            24'h000010, 1'b1, 2, 0, 16'h0);
    runCase("R10 dp zero base", 3'd0, 8'h44, 8'h00, 8'h00, 16'h0000, 16'h0, 16'h0, 16'h0, 8'h00, 1'b0,
            24'h000044, 1'b0, 2, 0, 16'h0);
    runCase("R3 stack", 3'd1, 8'h03, 8'h00, 8'h09, 16'h0400, 16'h01FC, 16'h0, 16'h0, 8'h12, 1'b0,
            24'h0001FF, 1'b0, 2, 0, 16'h0);
    runCase("R3 stack wrap", 3'd1, 8'hFF, 8'h00, 8'h00, 16'h0000, 16'hFF10, 16'h0, 16'h0, 8'h12, 1'b0,
            24'h00000F, 1'b0, 2, 0, 16'h0);
    runCase("R4 long", 3'd3, 8'h56, 8'h34, 8'h12, 16'h0100, 16'h0, 16'hFFFF, 16'h0, 8'h00, 1'b0,
            24'h123456, 1'b0, 2, 0, 16'h0);
    runCase("R5 long indexed", 3'd4, 8'hF0, 8'hFF, 8'h12, 16'h0, 16'h0, 16'hFFFF, 16'h0, 8'h00, 1'b0,
            24'h13FFEF, 1'b0, 2, 0, 16'h0);
    runCase("R6 long indexed 8-bit", 3'd4, 8'hF0, 8'hFF, 8'h12, 16'h0, 16'h0, 16'hAB80, 16'h0, 8'h00, 1'b1,
            24'h130070, 1'b0, 2, 0, 16'h0);
    runCase("R7 stack pointer", 3'd2, 8'h05, 8'h00, 8'h00, 16'h0200, 16'h1F00, 16'h0, 16'h8000, 8'h7E, 1'b0,
            {8'h7E, ptr16(16'h1F05)} + 24'h008000, 1'b0, 5, 2, 16'h1F05);
    runCase("R6 stack pointer 8-bit", 3'd2, 8'hFF, 8'h00, 8'h00, 16'h0000, 16'hFFFF, 16'h0, 16'h12FF, 8'h01, 1'b1,
            {8'h01, ptr16(16'h00FE)} + 24'h0000FF, 1'b0, 5, 2, 16'h00FE);
    runCase("R8 long pointer", 3'd5, 8'h40, 8'h00, 8'h00, 16'h0300, 16'h0, 16'h0, 16'hFFFF, 8'h55, 1'b0,
            ptr24(16'h0340), 1'b1, 6, 3, 16'h0340);
    runCase("R8 long pointer indexed", 3'd6, 8'hFE, 8'h00, 8'h00, 16'h0000, 16'h0, 16'h0, 16'hC321, 8'h55, 1'b0,
            ptr24(16'h00FE) + 24'h00C321, 1'b0, 6, 3, 16'h00FE);
    runCase("R8 long pointer wrap", 3'd6, 8'hFF, 8'h00, 8'h00, 16'hFFFF, 16'h0, 16'h0, 16'h00A0, 8'h00, 1'b1,
            ptr24(16'h00FE) + 24'h0000A0, 1'b1, 6, 3, 16'h00FE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule